// File: doc/BRIEF.md
# UART Interrupt Flag Controller

This block holds the sticky interrupt flags of a FIFO-based serial port together with their enable mask, and drives one interrupt request line. Three sources are single-cycle event pulses from the receiver: a framing error, a parity error and a receive overrun. The other three come from FIFO occupancy. One is the receive count reaching a programmable threshold. One is the transmit count falling to a single byte. The last is the transmit count dropping to half the FIFO capacity or below.

Software reads the flag word and the enable word from two output buses. It writes the enable word through one strobe and clears flags through another, using the same data bus. A flag is cleared by writing a one to its position. Occupancy flags fire only on the cycle their condition becomes true. A flag that software has cleared therefore stays cleared while the FIFO level stays put.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Flag and enable bit positions are frame error 0, parity error 1, overrun 3, RX threshold 4, TX one-left 5, TX half-or-less 6. Bits 2 and 7 always read 0, and writes to them have no effect.
- R2: A one-cycle pulse on an error event input sets its flag, which reads 1 from the cycle after the pulse.
- R3: When `sts_wr` is high, each flag whose `wr_data` bit is 1 is cleared on that clock edge. Flags whose `wr_data` bit is 0 keep their value.
- R4: If a hardware set and a software clear hit the same flag on the same edge, the flag ends up set.
- R5: The RX threshold flag sets on the edge where `rx_count >= rx_thresh` first becomes true. A threshold of 0 never sets the flag.
- R6: The TX one-left flag sets on the edge where `tx_count == 1` first becomes true.
- R7: The TX half flag sets on the edge where `tx_count <= FIFO_DEPTH/2` (4 by default) first becomes true.
- R8: An occupancy flag is not set again while its condition stays true. Out of reset, every occupancy condition is treated as already true, so a condition that holds at reset does not set its flag.
- R9: When `en_wr` is high, `wr_data` is loaded into the enable word, with bits 2 and 7 forced to 0.
- R10: `irq` is high exactly when some flag and its enable bit are both 1. It follows the registered flags and enables with no added delay.
- R11: Reset (`rst_n` low) clears all flags and all enable bits, and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_frame_err | input | 1 | Framing error pulse from the receiver |
| ev_parity_err | input | 1 | Parity error pulse from the receiver |
| ev_overrun | input | 1 | Receive FIFO overrun pulse |
| rx_count | input | CNT_W | Current receive FIFO occupancy |
| tx_count | input | CNT_W | Current transmit FIFO occupancy |
| rx_thresh | input | THR_W | Programmed receive threshold |
| en_wr | input | 1 | Write strobe for the enable word |
| sts_wr | input | 1 | Write-one-to-clear strobe for the flag word |
| wr_data | input | 8 | Write data for both strobes |
| enable_q | output | 8 | Enable word readback |
| status_q | output | 8 | Flag word readback |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a clear that lands while an occupancy condition is still true. Edge detection must then keep the flag clear, and that can only be seen if the FIFO count is held steady across several cycles after the write. The stimulus parks `tx_count` at 1 and `rx_count` at the threshold, clears the flags, and waits. It then moves each count out of its condition and back in to show the flag fires again. A separate step aligns an error pulse with a clear of the same bit, so that the set-wins rule is exercised. A randomized stretch then mixes slowly moving counts, pulses and strobes, and checks against the bench model on every clock.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = $clog2(FIFO_DEPTH) + 1,
  parameter int THR_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_frame_err,
  input  logic             ev_parity_err,
  input  logic             ev_overrun,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [THR_W-1:0] rx_thresh,
  input  logic             en_wr,
  input  logic             sts_wr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       enable_q,
  output logic [7:0]       status_q,
  output logic             irq
);

  localparam int          HALF = FIFO_DEPTH / 2;
  localparam logic [7:0]  LIVE = 8'b0111_1011;

  logic       cond_rx, cond_one, cond_half;
  logic [2:0] cond_prev;
  logic [7:0] hw_set, sw_clr;

  assign cond_rx   = (rx_thresh != '0) && (32'(rx_count) >= 32'(rx_thresh));
  assign cond_one  = (32'(tx_count) == 32'd1);
  assign cond_half = (32'(tx_count) <= 32'(HALF));

  assign hw_set = {1'b0,
                   cond_half & ~cond_prev[2],
                   cond_one  & ~cond_prev[1],
                   cond_rx   & ~cond_prev[0],
                   ev_overrun, 1'b0, ev_parity_err, ev_frame_err};
  assign sw_clr = sts_wr ? wr_data : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_prev <= 3'b111;
      status_q  <= 8'h00;
      enable_q  <= 8'h00;
    end else begin
      cond_prev <= {cond_half, cond_one, cond_rx};
      status_q  <= ((status_q & ~sw_clr) | hw_set) & LIVE;
      if (en_wr) enable_q <= wr_data & LIVE;
    end
  end

  assign irq = |(status_q & enable_q);

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[2] == 1'b0) && (status_q[7] == 1'b0) && (enable_q[2] == 1'b0) && (enable_q[7] == 1'b0));

  p_err_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_err |=> status_q[0]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wr_data[3] && !ev_overrun) |=> !status_q[3]);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[1] && !(sts_wr && wr_data[1])) |=> status_q[1]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_parity_err && sts_wr && wr_data[1]) |=> status_q[1]);

  p_no_retrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(tx_count) && !status_q[5]) |=> !status_q[5]);

  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == 8'h00) |-> !irq);

endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic       clk = 0, rst_n = 0;
  logic       ev_f = 0, ev_p = 0, ev_o = 0;
  logic [3:0] rxc = 0, txc = 0, thr = 0;
  logic       en_wr = 0, sts_wr = 0;
  logic [7:0] wd = 0;
  logic [7:0] enable_q, status_q;
  logic       irq;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_sts = 0, m_en = 0;
  bit p_rx = 1, p_one = 1, p_half = 1;

  always #2 clk = ~clk;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_frame_err(ev_f), .ev_parity_err(ev_p),
    .ev_overrun(ev_o), .rx_count(rxc), .tx_count(txc), .rx_thresh(thr),
    .en_wr(en_wr), .sts_wr(sts_wr), .wr_data(wd),
    .enable_q(enable_q), .status_q(status_q), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; p_rx = 1; p_one = 1; p_half = 1;
    end else begin
      bit c_rx, c_one, c_half;
      int s;
      c_rx   = (thr != 0) && (int'(rxc) >= int'(thr));
      c_one  = (txc == 1);
      c_half = (int'(txc) <= 4);
      s = m_sts;
      if (sts_wr) s = s & ~int'(wd);
      if (ev_f) s = s | 1;
      if (ev_p) s = s | 2;
      if (ev_o) s = s | 8;
      if (c_rx && !p_rx) s = s | 16;
      if (c_one && !p_one) s = s | 32;
      if (c_half && !p_half) s = s | 64;
      m_sts = s & 'h7B;
      p_rx = c_rx; p_one = c_one; p_half = c_half;
      if (en_wr) m_en = int'(wd) & 'h7B;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    check("R10 model irq", int'(irq), int'((m_sts & m_en) != 0));
    check("R1 model status", int'(status_q), m_sts);
    check("R9 model enable", int'(enable_q), m_en);
    ev_f = 0; ev_p = 0; ev_o = 0; en_wr = 0; sts_wr = 0; wd = 0;
  endtask

  initial begin
    #40000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset status", int'(status_q), 0);
    check("R11 reset enable", int'(enable_q), 0);
    check("R11 reset irq", int'(irq), 0);
    rst_n = 1;
    step();
    check("R8 no set at reset", int'(status_q), 0);

    en_wr = 1; wd = 8'hFF; step();
    check("R9 enable readback", int'(enable_q), 'h7B);
    check("R1 reserved enable bits", int'(enable_q & 8'h84), 0);

    ev_f = 1; step();
    check("R2 frame flag", int'(status_q), 'h01);
    check("R10 irq on flag", int'(irq), 1);

    sts_wr = 1; wd = 8'hFE; step();
    check("R3 write 0 keeps", int'(status_q), 'h01);
    sts_wr = 1; wd = 8'h01; step();
    check("R3 write 1 clears", int'(status_q), 'h00);
    check("R10 irq drops", int'(irq), 0);

    ev_p = 1; sts_wr = 1; wd = 8'h02; step();
    check("R4 set wins", int'(status_q), 'h02);
    ev_o = 1; step();
    check("R2 overrun flag", int'(status_q), 'h0A);
    sts_wr = 1; wd = 8'hFF; step();
    check("R3 clear all", int'(status_q), 0);

    thr = 3; rxc = 2; step();
    check("R5 below threshold", int'(status_q[4]), 0);
    rxc = 3; step();
    check("R5 threshold reached", int'(status_q[4]), 1);
    sts_wr = 1; wd = 8'h10; step();
    step(); step();
    check("R8 rx no retrigger", int'(status_q[4]), 0);
    rxc = 1; step();
    rxc = 5; step();
    check("R5 rearm and set", int'(status_q[4]), 1);
    sts_wr = 1; wd = 8'h10; thr = 0; rxc = 0; step();
    rxc = 8; step();
    check("R5 threshold zero never", int'(status_q[4]), 0);

    txc = 6; step();
    check("R7 above half no set", int'(status_q & 8'h60), 0);
    txc = 1; step();
    check("R6 one-left set", int'(status_q[5]), 1);
    check("R7 half set", int'(status_q[6]), 1);
    sts_wr = 1; wd = 8'h60; step();
    step(); step();
    check("R8 tx no retrigger", int'(status_q & 8'h60), 0);
    txc = 6; step();
    txc = 4; step();
    check("R7 half at 4", int'(status_q & 8'h60), 'h40);

    en_wr = 1; wd = 8'h01; step();
    check("R10 masked source", int'(irq), 0);
    ev_f = 1; step();
    check("R10 enabled source", int'(irq), 1);

    for (int i = 0; i < 400; i++) begin
      ev_f = ($urandom % 6) == 0;
      ev_p = ($urandom % 6) == 0;
      ev_o = ($urandom % 7) == 0;
      if (($urandom % 3) == 0) rxc = 4'($urandom % 9);
      if (($urandom % 3) == 0) txc = 4'($urandom % 9);
      if (($urandom % 20) == 0) thr = 4'($urandom);
      sts_wr = ($urandom % 4) == 0;
      en_wr  = ($urandom % 10) == 0;
      wd = 8'($urandom);
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule